// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Sequencer

This block sits between a synchronous host and a fast asynchronous static RAM. The host offers one read or one write at a time over a valid/ready handshake. The block turns each request into the memory's active-low chip enable, output enable and write enable, together with a registered address and write-data bus. Each strobe phase lasts a whole number of clock cycles. That number is derived from the memory's nanosecond timing figures and the clock period, so one parameter set retargets the sequencer to another clock or another speed grade. The defaults describe the 25 ns grade at a 10 ns clock.

A read holds chip enable and output enable low until both the address access time and the output-enable access time have passed, and until the read cycle time has been met. It captures the memory data on the edge that ends the read and returns it with a single-cycle valid strobe. A write lowers write enable only once the bus is known to be released. This covers the high-impedance window after a preceding read. Write enable stays low long enough to meet the pulse width, the data setup time and the address-valid time. Address, data and chip enable are then held one extra cycle after write enable rises. The nonvolatile-enable pin of the memory is tied inactive (high).

Top module: `sram_seq_top`

## Requirements
- R1: While and just after reset, reqReady is 1, sramCeN, sramOeN and sramWeN are 1, sramDqOe is 0 and rdValid is 0.
- R2: sramNeN is 1 in every cycle.
- R3: A read accepted on edge k drives sramCeN and sramOeN low with sramAddr equal to the accepted address from edge k up to edge k+RD_LEN. RD_LEN is the ceiling of the largest of read cycle time, address access time and output-enable access time divided by the clock period, with a minimum of 1 (3 by default). Both strobes rise together on edge k+RD_LEN.
- R4: rdData takes the value on sramDqIn at edge k+RD_LEN, and rdValid is 1 for exactly the one cycle that follows.
- R5: During a write, sramWeN is low for exactly WP_LEN cycles (2 by default). WP_LEN is the largest of the ceiling cycle counts for pulse width and data setup, and the address-valid count minus one. Throughout that time sramDqOe is 1, sramDqOut equals the accepted data and sramOeN is 1.
- R6: For HOLD_LEN cycles after sramWeN rises (1 by default), sramAddr, sramDqOut, sramDqOe=1 and sramCeN=0 are held. After that, sramCeN rises and sramDqOe falls on the same edge.
- R7: sramOeN is never low while sramWeN is low or sramDqOe is 1.
- R8: After sramOeN rises at the end of a read on edge r, a write accepted on edge a raises sramDqOe and lowers sramWeN on edge max(a+1, r+HZ_LEN). HZ_LEN is the ceiling of the output-disable time over the clock period (2 by default).
- R9: reqReady is 0 from the accepting edge until the request finishes. Values on reqValid, reqWrite, reqAddr and reqWdata during that time have no effect on the memory pins.
- R10: A write occupies drive-edge − accept-edge + WP_LEN + HOLD_LEN cycles before reqReady returns (4 with no pending bus release), and a read occupies RD_LEN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| rdValid | output | 1 | One-cycle strobe marking rdData valid |
| rdData | output | DATA_W | Captured read data |
| sramCeN | output | 1 | Memory chip enable, active low |
| sramOeN | output | 1 | Memory output enable, active low |
| sramWeN | output | 1 | Memory write enable, active low |
| sramNeN | output | 1 | Memory nonvolatile enable, held high |
| sramAddr | output | ADDR_W | Memory address |
| sramDqOut | output | DATA_W | Data driven toward the memory |
| sramDqOe | output | 1 | Drive enable for sramDqOut |
| sramDqIn | input | DATA_W | Data returned by the memory |

## Verification
Two functions can overlap. The first is the bus-release wait left behind by a read. The second is the start of a write accepted on the very next edge. The sweep places a write immediately after a read of the same address, then follows it with another read after a gap of zero or one idle cycles. For every write, the expected drive edge is recomputed from the recorded edge on which output enable rose. Each cycle in between is judged for write enable still high and the data bus still undriven. The data read back afterwards confirms that the write landed in the modelled memory.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef struct packed {
    logic load;     // latch request address and data
    logic capture;  // sample memory read data
    logic ceN;
    logic oeN;
    logic weN;
    logic dqOe;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WR_WAIT,
    ST_WR_PULSE,
    ST_WR_HOLD
  } seq_state_t;

  function automatic int cyclesFor(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int RD_LEN   = 3,
  parameter int WP_LEN   = 2,
  parameter int HOLD_LEN = 1,
  parameter int HZ_LEN   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int LONGEST = maxOf(RD_LEN, maxOf(WP_LEN, HOLD_LEN));
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int HZ_W    = $clog2(HZ_LEN + 1);

  seq_state_t state;
  logic [CNT_W-1:0] phaseCnt;
  logic [HZ_W-1:0]  hzCnt;
  logic ceNq, oeNq, weNq, dqOeq;
  logic accept, readDone, busFree;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign readDone = (state == ST_READ) && (phaseCnt == '0);
  assign busFree  = (hzCnt == '0);

  // bus-release window after output enable rises
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hzCnt <= '0;
    end else if (readDone) begin
      hzCnt <= HZ_W'(HZ_LEN - 1);
    end else if (hzCnt != '0) begin
      hzCnt <= hzCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      ceNq     <= 1'b1;
      oeNq     <= 1'b1;
      weNq     <= 1'b1;
      dqOeq    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ceNq <= 1'b0;
            if (reqWrite) begin
              state <= ST_WR_WAIT;
            end else begin
              oeNq     <= 1'b0;
              phaseCnt <= CNT_W'(RD_LEN - 1);
              state    <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (phaseCnt == '0) begin
            ceNq  <= 1'b1;
            oeNq  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_WR_WAIT: begin
          if (busFree) begin
            weNq     <= 1'b0;
            dqOeq    <= 1'b1;
            phaseCnt <= CNT_W'(WP_LEN - 1);
            state    <= ST_WR_PULSE;
          end
        end
        ST_WR_PULSE: begin
          if (phaseCnt == '0) begin
            weNq     <= 1'b1;
            phaseCnt <= CNT_W'(HOLD_LEN - 1);
            state    <= ST_WR_HOLD;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_WR_HOLD: begin
          if (phaseCnt == '0) begin
            ceNq  <= 1'b1;
            dqOeq <= 1'b0;
            state <= ST_IDLE;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = accept;
    strb.capture = readDone;
    strb.ceN     = ceNq;
    strb.oeN     = oeNq;
    strb.weN     = weNq;
    strb.dqOe    = dqOeq;
  end

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic              sramNeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              rdValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strb.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strb.capture;
      if (strb.capture) rdDataQ <= sramDqIn;
    end
  end

  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = strb.dqOe;
  assign sramCeN   = strb.ceN;
  assign sramOeN   = strb.oeN;
  assign sramWeN   = strb.weN;
  assign sramNeN   = 1'b1;
  assign rdData    = rdDataQ;
  assign rdValid   = rdValidQ;

endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 25,
  parameter int T_AA_NS       = 25,
  parameter int T_OE_NS       = 12,
  parameter int T_OHZ_NS      = 13,
  parameter int T_WC_NS       = 25,
  parameter int T_WP_NS       = 20,
  parameter int T_AW_NS       = 20,
  parameter int T_DS_NS       = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic              sramNeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int RD_LEN = maxOf(cyclesFor(T_RC_NS, CLK_PERIOD_NS),
                                cyclesFor(maxOf(T_AA_NS, T_OE_NS), CLK_PERIOD_NS));
  localparam int WP_LEN = maxOf(maxOf(cyclesFor(T_WP_NS, CLK_PERIOD_NS),
                                      cyclesFor(T_DS_NS, CLK_PERIOD_NS)),
                                cyclesFor(T_AW_NS, CLK_PERIOD_NS) - 1);
  localparam int HOLD_LEN = maxOf(1, cyclesFor(T_WC_NS, CLK_PERIOD_NS) - WP_LEN - 1);
  localparam int HZ_LEN   = cyclesFor(T_OHZ_NS, CLK_PERIOD_NS);

  strobe_t strb;

  sram_seq_ctrl #(
    .RD_LEN  (RD_LEN),
    .WP_LEN  (WP_LEN),
    .HOLD_LEN(HOLD_LEN),
    .HZ_LEN  (HZ_LEN)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sram_seq_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .sramDqIn (sramDqIn),
    .sramAddr (sramAddr),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe),
    .sramCeN  (sramCeN),
    .sramOeN  (sramOeN),
    .sramWeN  (sramWeN),
    .sramNeN  (sramNeN),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int HZ_LEN = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rdValid,
  input logic              sramCeN,
  input logic              sramOeN,
  input logic              sramWeN,
  input logic              sramNeN,
  input logic [ADDR_W-1:0] sramAddr,
  input logic [DATA_W-1:0] sramDqOut,
  input logic              sramDqOe
);

  localparam int SINCE_W = $clog2(HZ_LEN + 1) + 1;

  logic               oePrev;
  logic [SINCE_W-1:0] sinceOe;

  // cycles elapsed since output enable last rose, saturating at HZ_LEN
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oePrev  <= 1'b1;
      sinceOe <= SINCE_W'(HZ_LEN);
    end else begin
      oePrev <= sramOeN;
      if (sramOeN && !oePrev)
        sinceOe <= SINCE_W'(1);
      else if (sinceOe < SINCE_W'(HZ_LEN))
        sinceOe <= sinceOe + 1'b1;
    end
  end

  AST_NE_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    sramNeN == 1'b1); // R2

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && (!sramWeN || sramDqOe))); // R7

  AST_READ_CE_WITH_OE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramOeN) |-> !sramCeN); // R3

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R4

  AST_WE_FALL_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> (sramDqOe && !sramCeN)); // R5

  AST_WE_LOW_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!sramWeN && $past(!sramWeN)) |-> ($stable(sramAddr) && $stable(sramDqOut))); // R5

  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (sramDqOe && !sramCeN && $stable(sramAddr) && $stable(sramDqOut))); // R6

  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDqOe) |-> (sinceOe >= SINCE_W'(HZ_LEN))); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R9

endmodule

bind sram_seq_top sram_seq_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .HZ_LEN(HZ_LEN)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rdValid  (rdValid),
  .sramCeN  (sramCeN),
  .sramOeN  (sramOeN),
  .sramWeN  (sramWeN),
  .sramNeN  (sramNeN),
  .sramAddr (sramAddr),
  .sramDqOut(sramDqOut),
  .sramDqOe (sramDqOe)
);

// File: tb/sram_seq_top_tb.sv
`timescale 1ns/1ps
module sram_seq_top_tb_top;

  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PER    = 10;
  // expected phase lengths from the nanosecond figures
  localparam int RD_LEN   = (25 + PER - 1) / PER;
  localparam int WP_LEN   = (20 + PER - 1) / PER;
  localparam int HOLD_LEN = 1;
  localparam int HZ_LEN   = (13 + PER - 1) / PER;
  localparam int WDOG     = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqReady, rdValid, sramCeN, sramOeN, sramWeN, sramNeN, sramDqOe;
  logic [DATA_W-1:0] rdData, sramDqOut, sramDqIn;
  logic [ADDR_W-1:0] sramAddr;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] expMem [DEPTH];

  int checks = 0, failures = 0;
  int edgeCnt = 0;
  int lastOeRise = -1000;
  bit done = 0;

  always #(PER/2) clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  sram_seq_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .sramCeN(sramCeN), .sramOeN(sramOeN),
    .sramWeN(sramWeN), .sramNeN(sramNeN), .sramAddr(sramAddr),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  // asynchronous memory model
  assign sramDqIn = (!sramCeN && !sramOeN) ? mem[sramAddr] : '0;
  always @(posedge sramWeN) if (!sramCeN && sramDqOe) mem[sramAddr] <= sramDqOut;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // continuous pin rules, sampled mid-cycle
  always @(negedge clk) if (rstN && !done) begin
    chk(sramNeN == 1'b1, "R2", "sramNeN", sramNeN, 1);
    chk(!(!sramOeN && (!sramWeN || sramDqOe)), "R7", "oeN/weN/dqOe",
        {sramOeN, sramWeN, sramDqOe}, 3'b100);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic doRead(input int a, input int gap);
    int acc;
    idle(gap);
    reqValid = 1; reqWrite = 0; reqAddr = ADDR_W'(a);
    @(posedge clk); #1; acc = edgeCnt;
    chk(!reqReady && !sramCeN && !sramOeN && sramAddr == ADDR_W'(a) && !rdValid,
        "R3", "read start addr", sramAddr, a);
    reqAddr = ~ADDR_W'(a); reqWrite = 1;  // R9: changes while busy must be ignored
    for (int i = 1; i <= RD_LEN; i++) begin
      @(posedge clk); #1;
      if (i < RD_LEN)
        chk(!sramCeN && !sramOeN && sramWeN && sramAddr == ADDR_W'(a) && !rdValid && !reqReady,
            "R9", "read busy", {sramCeN, sramOeN, reqReady}, 0);
      else begin
        chk(rdValid && rdData == expMem[a], "R4", "read data", rdData, expMem[a]);
        chk(sramCeN && sramOeN && reqReady, "R10", "read end",
            {sramCeN, sramOeN, reqReady}, 3'b111);
      end
    end
    lastOeRise = acc + RD_LEN;
    reqValid = 0;
  endtask

  task automatic doWrite(input int a, input logic [DATA_W-1:0] d, input int gap);
    int acc, drive, endE, e;
    idle(gap);
    reqValid = 1; reqWrite = 1; reqAddr = ADDR_W'(a); reqWdata = d;
    @(posedge clk); #1; acc = edgeCnt;
    chk(!reqReady && !sramCeN && sramOeN && !rdValid, "R9", "write accept",
        {reqReady, sramCeN, sramOeN}, 3'b001);
    reqAddr = ~ADDR_W'(a); reqWdata = ~d; reqWrite = 0;  // R9 ignored while busy
    drive = (acc + 1 > lastOeRise + HZ_LEN) ? acc + 1 : lastOeRise + HZ_LEN;
    endE  = drive + WP_LEN + HOLD_LEN;
    while (edgeCnt < endE) begin
      @(posedge clk); #1; e = edgeCnt;
      if (e < drive)
        chk(sramWeN && !sramDqOe && !sramCeN && !reqReady && sramAddr == ADDR_W'(a),
            "R8", "bus release wait", {sramWeN, sramDqOe}, 2'b10);
      else if (e < drive + WP_LEN)
        chk(!sramWeN && sramDqOe && sramOeN && sramDqOut == d && sramAddr == ADDR_W'(a) && !reqReady,
            "R5", "write pulse data", sramDqOut, d);
      else if (e < endE)
        chk(sramWeN && sramDqOe && !sramCeN && sramDqOut == d && sramAddr == ADDR_W'(a) && !reqReady,
            "R6", "write hold", {sramWeN, sramDqOe, sramCeN}, 3'b110);
      else
        chk(sramCeN && !sramDqOe && reqReady && (e - acc) == (drive - acc + WP_LEN + HOLD_LEN),
            "R10", "write end", e - acc, drive - acc + WP_LEN + HOLD_LEN);
    end
    expMem[a] = d;
    reqValid = 0;
  endtask

  function automatic logic [DATA_W-1:0] pat1(input int a);
    return DATA_W'(a * 37 + (a >> 4) + 3);
  endfunction
  function automatic logic [DATA_W-1:0] pat2(input int a);
    return DATA_W'((a * 11) ^ 8'hA5 ^ (a >> 8));
  endfunction

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      mem[a] = DATA_W'(a) ^ 8'h5A;
      expMem[a] = DATA_W'(a) ^ 8'h5A;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(reqReady && sramCeN && sramOeN && sramWeN && !sramDqOe && !rdValid,
        "R1", "in reset", {reqReady, sramCeN, sramOeN, sramWeN, sramDqOe, rdValid}, 6'b111100);
    rstN = 1;
    @(posedge clk); #1;
    chk(reqReady && sramCeN && sramOeN && sramWeN && !sramDqOe && !rdValid,
        "R1", "after reset", {reqReady, sramCeN, sramOeN, sramWeN, sramDqOe, rdValid}, 6'b111100);
    // initial contents read before any write
    for (int a = 0; a < 16; a++) doRead(a, a % 2);
    // pass A: write every address with varied idle gaps
    for (int a = 0; a < DEPTH; a++) doWrite(a, pat1(a), a % 3);
    // pass B: read, immediate write (turnaround), read back
    for (int a = 0; a < DEPTH; a++) begin
      doRead(a, a % 2);
      doWrite(a, pat2(a), 0);
      doRead(a, (a >> 1) % 2);
    end
    finishRun();
  end

  initial begin
    wait (edgeCnt >= WDOG);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", edgeCnt, WDOG);
      finishRun();
    end
  end

endmodule